// File: doc/BRIEF.md
# Four-Channel Timer Compare Pulse Generator

This block watches a free-running timestamp counter through four independent compare channels. Each channel holds an active compare value. When the counter equals that value, the channel drives its output pin in the selected mode (a one-cycle high pulse or a level toggle) and sets its event flag. The channel also raises its interrupt line while the flag is set and interrupt generation is enabled for that channel.

Each channel's compare register is double-buffered, so software can queue the next event while the current one is still waiting. After a channel is turned off, the first compare write loads the active value directly. Later writes land in a pending slot, and that slot moves into the active value at the next match. Software therefore always writes the event that follows the one currently pending.

Each channel runs a three-state machine:
- `CH_IDLE`: no active value is loaded.
- `CH_ARMED`: an active value is loaded and nothing is pending.
- `CH_QUEUED`: an active value is loaded and a pending value is also held.

The transitions are:
- IDLE to ARMED on a compare write.
- ARMED to QUEUED on a compare write.
- QUEUED to ARMED on a match with no write in the same cycle.
- Any state to IDLE when the mode field is written as 0.

A global status word gathers the four event flags.

Top module: `cmp_pulse_bank`

## Requirements
- R1: Register map. The address is `{ch, sel}`, where `sel`=0 selects the channel control word and `sel`=1 selects the compare word. With four channels, channel n sits at addresses 2n and 2n+1, and address 8 reads the global status. The control word holds:
  - bit 0: request enable
  - bits 5:2: mode
  - bit 6: interrupt enable
  - bit 7: event flag

  Bits 0, 2 to 6 read back as written, and bit 1 always reads 0. All fields reset to 0.
- R2: Writing the control word with bit 7 = 1 clears the event flag. Writing bit 7 = 0 leaves the flag unchanged.
- R3: In mode 0xF, the pin is high for exactly one cycle: the cycle after the clock edge at which the counter equals the active value.
- R4: In mode 0x5, the pin inverts at each match and otherwise holds its level.
- R5: Mode 0 and any mode other than 0x5 or 0xF produce no matches and hold the pin low. A written mode reads back on the next cycle. Writing mode 0 returns the channel to `CH_IDLE`, so the next compare write reloads the active value.
- R6: In `CH_IDLE`, a compare write loads the active value. In the other states, a compare write goes to the pending slot, and a later write before the match replaces it.
- R7: At a match in `CH_QUEUED`, the pending value becomes the active value. Reading the compare word returns the active value.
- R8: At a match with nothing pending, the active value is kept and matches again the next time the counter reaches it.
- R9: The global status word carries the event flag of channel n in bit n.
- R10: `irq_o[n]` is high exactly while channel n's flag and interrupt enable are both set.
- R11: A match is exact equality, including a compare value of 0 reached when the counter wraps from its maximum.
- R12: When a match and a flag-clearing control write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Timestamp counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| pin_o | output | NCH | Per-channel compare output pins |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
A channel stuck in the wrong state shows up at the pins within one counter period:
- If the channel fails to leave `CH_IDLE`, the pin never moves.
- If it fails to advance from `CH_QUEUED`, the compare readback shows a stale value one cycle after the match.
- If it takes a write into the wrong slot, the pulse lands on the wrong counter value.

A flag or interrupt-enable fault appears on `irq_o` and in the status word in the cycle after the edge that set or cleared it. The bench therefore compares pins, flags and readback one cycle after each driven counter value.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ARMED  = 2'd1,
        CH_QUEUED = 2'd2
    } ch_state_t;

    localparam logic [3:0] MODE_OFF    = 4'h0;
    localparam logic [3:0] MODE_TOGGLE = 4'h5;
    localparam logic [3:0] MODE_PULSE  = 4'hF;

    localparam int BIT_REQ     = 0;
    localparam int BIT_MODE_LO = 2;
    localparam int BIT_MODE_HI = 5;
    localparam int BIT_IE      = 6;
    localparam int BIT_FLAG    = 7;

    typedef struct packed {
        logic       irq_en;
        logic [3:0] mode;
        logic       req_en;
    } ch_cfg_t;
endpackage

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmp_pkg::*;
#(
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          ctl_we,
    input  logic          cmp_we,
    input  logic [DW-1:0] wdata,
    output logic [3:0]    mode_o,
    output logic          hit_o,
    output logic          flag_o,
    output logic [7:0]    ctrl_o,
    output logic [CW-1:0] act_o
);
    ch_state_t     st, st_nx;
    ch_cfg_t       cfg;
    logic [CW-1:0] act, pend;
    logic          flag;
    logic          mode_live;
    logic          hit;
    logic          clr_req;
    logic          go_idle;

    assign mode_live = (cfg.mode == MODE_PULSE) || (cfg.mode == MODE_TOGGLE);
    assign hit       = mode_live && (st != CH_IDLE) && (cnt_i == act);
    assign clr_req   = ctl_we && wdata[BIT_FLAG];
    assign go_idle   = ctl_we && (wdata[BIT_MODE_HI:BIT_MODE_LO] == MODE_OFF);

    always_comb begin
        st_nx = st;
        unique case (st)
            CH_IDLE: begin
                if (cmp_we) st_nx = CH_ARMED;
            end
            CH_ARMED: begin
                if (go_idle)     st_nx = CH_IDLE;
                else if (cmp_we) st_nx = CH_QUEUED;
            end
            CH_QUEUED: begin
                if (go_idle)             st_nx = CH_IDLE;
                else if (hit && !cmp_we) st_nx = CH_ARMED;
            end
            default: st_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= '0;
            pend <= '0;
            cfg  <= '0;
            flag <= 1'b0;
        end else begin
            if (st == CH_IDLE && cmp_we)       act <= wdata[CW-1:0];
            else if (st == CH_QUEUED && hit)   act <= pend;
            if (st != CH_IDLE && cmp_we)       pend <= wdata[CW-1:0];
            if (ctl_we) begin
                cfg.req_en <= wdata[BIT_REQ];
                cfg.mode   <= wdata[BIT_MODE_HI:BIT_MODE_LO];
                cfg.irq_en <= wdata[BIT_IE];
            end
            if (hit)          flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;
        end
    end

    assign mode_o = cfg.mode;
    assign hit_o  = hit;
    assign flag_o = flag;
    assign act_o  = act;
    assign ctrl_o = {flag, cfg.irq_en, cfg.mode, 1'b0, cfg.req_en};

    // R7
    queue_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_QUEUED && hit) |=> (act == $past(pend)));

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

    // R8
    armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_ARMED && hit && !cmp_we && !ctl_we) |=> (act == $past(act)));
endmodule

// File: rtl/cmp_pin_drive.sv
module cmp_pin_drive
    import cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  logic       hit,
    output logic       pin_o
);
    logic pin;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            case (mode)
                MODE_PULSE:  pin <= hit;
                MODE_TOGGLE: pin <= pin ^ hit;
                default:     pin <= 1'b0;
            endcase
        end
    end

    assign pin_o = pin;

    // R3
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin) && $past(mode) == MODE_PULSE) |-> $past(hit));

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_TOGGLE) |=> (pin != $past(pin)));
endmodule

// File: rtl/cmp_regmux.sv
module cmp_regmux #(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int DW  = 32,
    parameter int AW  = 4
) (
    input  logic [AW-1:0]          rd_addr,
    input  logic [NCH-1:0][7:0]    ctrl_i,
    input  logic [NCH-1:0][CW-1:0] act_i,
    input  logic [NCH-1:0]         flag_i,
    output logic [DW-1:0]          rd_data
);
    localparam int SEL_W = AW - 2;

    logic [SEL_W-1:0] ch;

    assign ch = rd_addr[AW-2:1];

    always_comb begin
        rd_data = '0;
        if (rd_addr[AW-1]) begin
            rd_data[NCH-1:0] = flag_i;
        end else if (rd_addr[0]) begin
            rd_data = DW'(act_i[ch]);
        end else begin
            rd_data[7:0] = ctrl_i[ch];
        end
    end
endmodule

// File: rtl/cmp_pulse_bank.sv
module cmp_pulse_bank
    import cmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int DW  = 32,
    parameter int AW  = $clog2(NCH) + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt_i,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] irq_o
);
    logic [NCH-1:0][7:0]    ctrl_w;
    logic [NCH-1:0][CW-1:0] act_w;
    logic [NCH-1:0]         flag_w;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic       ctl_we, cmp_we, hit;
        logic [3:0] mode;

        assign ctl_we = wr_en && (wr_addr == AW'(2 * n));
        assign cmp_we = wr_en && (wr_addr == AW'(2 * n + 1));

        cmp_channel #(.CW(CW), .DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt_i),
            .ctl_we (ctl_we),
            .cmp_we (cmp_we),
            .wdata  (wr_data),
            .mode_o (mode),
            .hit_o  (hit),
            .flag_o (flag_w[n]),
            .ctrl_o (ctrl_w[n]),
            .act_o  (act_w[n])
        );

        cmp_pin_drive u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .hit   (hit),
            .pin_o (pin_o[n])
        );

        assign irq_o[n] = flag_w[n] & ctrl_w[n][BIT_IE];
    end

    cmp_regmux #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_mux (
        .rd_addr (rd_addr),
        .ctrl_i  (ctrl_w),
        .act_i   (act_w),
        .flag_i  (flag_w),
        .rd_data (rd_data)
    );
endmodule

// File: tb/tb_cmp_pulse_bank.sv
module tb_cmp_pulse_bank;
    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int DW  = 32;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [CW-1:0]  cnt_i = '0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [DW-1:0]  rd_data;
    logic [NCH-1:0] pin_o, irq_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    cmp_pulse_bank #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_o(pin_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Vector: {counter value, expected pin0, expected flag0} for channel 0
    // in mode 0xF with active 5 and pending 9.
    localparam logic [9:0] VEC [0:5] = '{
        {8'd4,  1'b0, 1'b0},
        {8'd5,  1'b1, 1'b1},
        {8'd6,  1'b0, 1'b1},
        {8'd9,  1'b1, 1'b1},
        {8'd10, 1'b0, 1'b1},
        {8'd9,  1'b1, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        wrap_up();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // Reset state: R1, R9, R10
        rd(4'd0, v); chk("R1 reset ctrl", v, 0);
        rd(4'd8, v); chk("R9 reset status", v, 0);
        chk("R10 reset irq", {28'd0, irq_o}, 0);
        chk("R3 reset pins", {28'd0, pin_o}, 0);

        // Channel 0 setup, then walk the vector table (R3, R6, R7, R8)
        wr(4'd1, 32'd5);
        wr(4'd0, 32'h3C);
        wr(4'd1, 32'd9);
        foreach (VEC[i]) begin
            cnt_i = VEC[i][9:2];
            tick();
            chk("R3 pulse pin", {31'd0, pin_o[0]}, {31'd0, VEC[i][1]});
            rd(4'd0, v);
            chk("R8 flag", {31'd0, v[7]}, {31'd0, VEC[i][0]});
        end
        cnt_i = 8'd0;

        // R2: write 0 to bit 7 keeps flag, write 1 clears it
        wr(4'd0, 32'h3C); rd(4'd0, v); chk("R2 keep flag", v, 32'hBC);
        wr(4'd0, 32'hBC); rd(4'd0, v); chk("R2 clear flag", v, 32'h3C);

        // R10 / R9: interrupt and status
        wr(4'd0, 32'h7C);
        chk("R10 irq off", {31'd0, irq_o[0]}, 0);
        cnt_i = 8'd9; tick();
        chk("R10 irq on", {31'd0, irq_o[0]}, 1);
        rd(4'd8, v); chk("R9 status", v, 32'h1);

        // R12: match and clear in the same cycle
        wr(4'd0, 32'hFC); rd(4'd0, v); chk("R12 set wins", {31'd0, v[7]}, 1);
        cnt_i = 8'd0;
        wr(4'd0, 32'hFC); rd(4'd0, v); chk("R12 later clear", {31'd0, v[7]}, 0);

        // R1 / R5: readback and a non-compare mode on channel 1
        wr(4'd2, 32'h47); rd(4'd2, v); chk("R1 ctrl readback", v, 32'h45);
        wr(4'd3, 32'd20); rd(4'd3, v); chk("R6 idle load", v, 32'd20);
        cnt_i = 8'd20; tick();
        rd(4'd2, v); chk("R5 other mode no flag", {31'd0, v[7]}, 0);
        chk("R5 other mode pin low", {31'd0, pin_o[1]}, 0);

        // R11: compare value 0 reached by wrap
        wr(4'd2, 32'h00); rd(4'd2, v); chk("R5 mode reads 0", v, 0);
        wr(4'd3, 32'd0); rd(4'd3, v); chk("R5 idle reload", v, 0);
        wr(4'd2, 32'h3C);
        cnt_i = 8'd255; tick(); chk("R11 before wrap", {31'd0, pin_o[1]}, 0);
        cnt_i = 8'd0;   tick(); chk("R11 wrap match", {31'd0, pin_o[1]}, 1);
        cnt_i = 8'd1;

        // R4: toggle mode on channel 2
        wr(4'd5, 32'd3); wr(4'd4, 32'h14); wr(4'd5, 32'd7);
        cnt_i = 8'd3; tick(); chk("R4 toggle up", {31'd0, pin_o[2]}, 1);
        cnt_i = 8'd7; tick(); chk("R4 toggle down", {31'd0, pin_o[2]}, 0);
        rd(4'd5, v); chk("R7 advanced", v, 32'd7);
        tick(); chk("R8 rematch", {31'd0, pin_o[2]}, 1);
        cnt_i = 8'd1; tick(); chk("R4 hold", {31'd0, pin_o[2]}, 1);
        wr(4'd4, 32'h00); tick(); chk("R5 off pin low", {31'd0, pin_o[2]}, 0);

        // R6: pending overwrite on channel 3
        wr(4'd7, 32'd10); wr(4'd6, 32'h3C); wr(4'd7, 32'd20); wr(4'd7, 32'd30);
        cnt_i = 8'd10; tick(); chk("R6 first match", {31'd0, pin_o[3]}, 1);
        rd(4'd7, v); chk("R6 overwrite", v, 32'd30);
        cnt_i = 8'd20; tick(); chk("R6 stale skipped", {31'd0, pin_o[3]}, 0);
        cnt_i = 8'd30; tick(); chk("R6 new match", {31'd0, pin_o[3]}, 1);

        // R5: mode clear returns to idle
        cnt_i = 8'd1;
        wr(4'd6, 32'h00); rd(4'd6, v); chk("R5 cleared mode", v, 32'h80);
        cnt_i = 8'd30; tick(); chk("R5 no match off", {31'd0, pin_o[3]}, 0);
        wr(4'd7, 32'd40); rd(4'd7, v); chk("R5 reload after off", v, 32'd40);

        rd(4'd8, v); chk("R9 final status", v, 32'hE);
        wrap_up();
    end
endmodule